// File: doc/BRIEF.md
# Register Renamer with In-Order Retirement

This block maps architectural register numbers onto a larger pool of physical registers, so that an out-of-order core can issue instructions without false write-after-write or write-after-read hazards. Each accepted rename looks up the two source registers in a map table and takes a fresh physical register for the destination from a first-in first-out free pool. It also records the destination's displaced physical register in a circular in-flight list, and returns that list slot as a tag.

Execution units report finished work by tag. The oldest in-flight entry leaves the list as soon as it is marked finished, and never earlier. When it leaves, its displaced physical register goes back to the tail of the free pool. A register that a later instruction has overwritten is therefore recycled only once the overwriting instruction is final. Recovery after a misprediction, operand storage and execution are handled outside the block.

Top module: `regRenamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free pool holds physical registers 32 to 63 in increasing order. The in-flight list is empty, so `renTag` is 0 and `retValid` is 0.
- R2: `physSrcA` and `physSrcB` show, in the same cycle, the current mapping of `renSrcA` and `renSrcB`. A source equal to the destination of the same rename reads the mapping from before that rename.
- R3: An accepted rename reports the destination's previous mapping on `physOld`. From the next cycle on, the destination maps to the `physDst` it was given.
- R4: `physDst` is the oldest entry of the free pool. Released registers join the pool at its tail and are handed out again in release order.
- R5: `renTag` is the in-flight list slot of the rename. It starts at 0 and advances by one for each accepted rename, wrapping from 31 to 0.
- R6: A pulse on `cmpValid` marks the entry at `cmpTag` finished. A finished entry that is not the oldest does not leave the list.
- R7: Whenever the oldest in-flight entry is finished, `retValid` is 1 and `retPhys` carries that entry's displaced register. The entry leaves on that clock edge, one entry per cycle, in program order.
- R8: `renReady` is 0 when the free pool is empty or all 32 list slots are in use. A `renValid` while `renReady` is 0 changes no mapping, no tag and no pool entry.
- R9: A rename and a retirement in the same cycle leave the free-pool occupancy and the in-flight occupancy unchanged. The register released in that cycle becomes available to later renames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request |
| renSrcA | input | 5 | First architectural source |
| renSrcB | input | 5 | Second architectural source |
| renDst | input | 5 | Architectural destination |
| renReady | output | 1 | Rename can be accepted this cycle |
| physSrcA | output | 6 | Physical register of first source |
| physSrcB | output | 6 | Physical register of second source |
| physDst | output | 6 | Newly assigned physical destination |
| physOld | output | 6 | Displaced mapping of the destination |
| renTag | output | 5 | In-flight list slot of this rename |
| cmpValid | input | 1 | Completion report |
| cmpTag | input | 5 | Slot of the completed instruction |
| retValid | output | 1 | Oldest entry retires this cycle |
| retPhys | output | 6 | Physical register released by the retirement |

## Verification
The hardest state to reach is a single cycle in which the list is full and one register has just been released while a new rename arrives, so that an allocation and a release meet. The stimulus first retires a few entries to move both ring pointers away from zero. It then renames until the pool runs dry and attempts an extra rename while stalled. Next it finishes the two oldest entries in back-to-back cycles, and holds a rename request pending so that it lands exactly in the second retirement cycle. After that, a single further rename must fill the block again. Completions are also issued out of order, so the oldest entry has to hold back finished younger ones.

// File: rtl/renamePkg.sv
`timescale 1ns/1ps
package renamePkg;
  typedef struct packed {
    logic alloc;
    logic retire;
    logic complete;
  } renStrobeT;
endpackage

// File: rtl/renameCtrl.sv
`timescale 1ns/1ps
module renameCtrl
  import renamePkg::*;
#(
  parameter int AL_DEPTH   = 32,
  parameter int FREE_DEPTH = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic renValid,
  input  logic cmpValid,
  input  logic headDone,
  output renStrobeT strobe,
  output logic renReady,
  output logic retValid,
  output logic [$clog2(AL_DEPTH)-1:0]   alHead,
  output logic [$clog2(AL_DEPTH)-1:0]   alTail,
  output logic [$clog2(FREE_DEPTH)-1:0] freeHead,
  output logic [$clog2(FREE_DEPTH)-1:0] freeTail
);
  localparam int AL_PW   = $clog2(AL_DEPTH);
  localparam int FREE_PW = $clog2(FREE_DEPTH);
  localparam int AL_CW   = $clog2(AL_DEPTH + 1);
  localparam int FREE_CW = $clog2(FREE_DEPTH + 1);
  localparam logic [AL_PW-1:0]   AL_LAST   = AL_PW'(AL_DEPTH - 1);
  localparam logic [FREE_PW-1:0] FREE_LAST = FREE_PW'(FREE_DEPTH - 1);

  logic [AL_CW-1:0]   alCount;
  logic [FREE_CW-1:0] freeCount;

  always_comb begin
    renReady        = (freeCount != '0) && (alCount != AL_CW'(AL_DEPTH));
    retValid        = (alCount != '0) && headDone;
    strobe.alloc    = renValid && renReady;
    strobe.retire   = retValid;
    strobe.complete = cmpValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alHead    <= '0;
      alTail    <= '0;
      freeHead  <= '0;
      freeTail  <= '0;
      alCount   <= '0;
      freeCount <= FREE_CW'(FREE_DEPTH);
    end else begin
      if (strobe.alloc) begin
        alTail   <= (alTail == AL_LAST) ? '0 : alTail + 1'b1;
        freeHead <= (freeHead == FREE_LAST) ? '0 : freeHead + 1'b1;
      end
      if (strobe.retire) begin
        alHead   <= (alHead == AL_LAST) ? '0 : alHead + 1'b1;
        freeTail <= (freeTail == FREE_LAST) ? '0 : freeTail + 1'b1;
      end
      case ({strobe.alloc, strobe.retire})
        2'b10: begin
          alCount   <= alCount + 1'b1;
          freeCount <= freeCount - 1'b1;
        end
        2'b01: begin
          alCount   <= alCount - 1'b1;
          freeCount <= freeCount + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R9
  count_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(freeCount) + 32'(alCount)) == FREE_DEPTH);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !renReady) |=> ($stable(alTail) && $stable(freeHead)));

endmodule

// File: rtl/renameData.sv
`timescale 1ns/1ps
module renameData
  import renamePkg::*;
#(
  parameter int LOG_REGS  = 32,
  parameter int PHYS_REGS = 64,
  parameter int AL_DEPTH  = 32
) (
  input  logic clk,
  input  logic rstN,
  input  renStrobeT strobe,
  input  logic [$clog2(LOG_REGS)-1:0] renSrcA,
  input  logic [$clog2(LOG_REGS)-1:0] renSrcB,
  input  logic [$clog2(LOG_REGS)-1:0] renDst,
  input  logic [$clog2(AL_DEPTH)-1:0] cmpTag,
  input  logic [$clog2(AL_DEPTH)-1:0] alHead,
  input  logic [$clog2(AL_DEPTH)-1:0] alTail,
  input  logic [$clog2(PHYS_REGS-LOG_REGS)-1:0] freeHead,
  input  logic [$clog2(PHYS_REGS-LOG_REGS)-1:0] freeTail,
  output logic [$clog2(PHYS_REGS)-1:0] physSrcA,
  output logic [$clog2(PHYS_REGS)-1:0] physSrcB,
  output logic [$clog2(PHYS_REGS)-1:0] physNew,
  output logic [$clog2(PHYS_REGS)-1:0] physOld,
  output logic headDone,
  output logic [$clog2(PHYS_REGS)-1:0] headOld
);
  localparam int PHYS_W     = $clog2(PHYS_REGS);
  localparam int FREE_DEPTH = PHYS_REGS - LOG_REGS;

  logic [PHYS_W-1:0] mapTab  [LOG_REGS];
  logic [PHYS_W-1:0] freeMem [FREE_DEPTH];
  logic [PHYS_W-1:0] alOld   [AL_DEPTH];
  logic [AL_DEPTH-1:0] alDone;

  always_comb begin
    physSrcA = mapTab[renSrcA];
    physSrcB = mapTab[renSrcB];
    physOld  = mapTab[renDst];
    physNew  = freeMem[freeHead];
    headDone = alDone[alHead];
    headOld  = alOld[alHead];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LOG_REGS; i++) mapTab[i] <= PHYS_W'(i);
      for (int i = 0; i < FREE_DEPTH; i++) freeMem[i] <= PHYS_W'(LOG_REGS + i);
      for (int i = 0; i < AL_DEPTH; i++) alOld[i] <= '0;
      alDone <= '0;
    end else begin
      if (strobe.alloc) begin
        mapTab[renDst] <= physNew;
        alOld[alTail]  <= physOld;
        alDone[alTail] <= 1'b0;
      end
      if (strobe.complete) alDone[cmpTag] <= 1'b1;
      if (strobe.retire) freeMem[freeTail] <= headOld;
    end
  end

  // R3
  map_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> (mapTab[$past(renDst)] == $past(physNew)));

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.complete |=> alDone[$past(cmpTag)]);

endmodule

// File: rtl/regRenamer.sv
`timescale 1ns/1ps
module regRenamer
  import renamePkg::*;
#(
  parameter int LOG_REGS  = 32,
  parameter int PHYS_REGS = 64,
  parameter int AL_DEPTH  = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic renValid,
  input  logic [$clog2(LOG_REGS)-1:0] renSrcA,
  input  logic [$clog2(LOG_REGS)-1:0] renSrcB,
  input  logic [$clog2(LOG_REGS)-1:0] renDst,
  output logic renReady,
  output logic [$clog2(PHYS_REGS)-1:0] physSrcA,
  output logic [$clog2(PHYS_REGS)-1:0] physSrcB,
  output logic [$clog2(PHYS_REGS)-1:0] physDst,
  output logic [$clog2(PHYS_REGS)-1:0] physOld,
  output logic [$clog2(AL_DEPTH)-1:0] renTag,
  input  logic cmpValid,
  input  logic [$clog2(AL_DEPTH)-1:0] cmpTag,
  output logic retValid,
  output logic [$clog2(PHYS_REGS)-1:0] retPhys
);
  localparam int FREE_DEPTH = PHYS_REGS - LOG_REGS;
  localparam int AL_PW      = $clog2(AL_DEPTH);
  localparam int FREE_PW    = $clog2(FREE_DEPTH);

  renStrobeT strobe;
  logic headDone;
  logic [AL_PW-1:0]   alHead, alTail;
  logic [FREE_PW-1:0] freeHead, freeTail;

  renameCtrl #(.AL_DEPTH(AL_DEPTH), .FREE_DEPTH(FREE_DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .cmpValid(cmpValid),
    .headDone(headDone), .strobe(strobe), .renReady(renReady),
    .retValid(retValid), .alHead(alHead), .alTail(alTail),
    .freeHead(freeHead), .freeTail(freeTail)
  );

  renameData #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS), .AL_DEPTH(AL_DEPTH)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst), .cmpTag(cmpTag),
    .alHead(alHead), .alTail(alTail), .freeHead(freeHead), .freeTail(freeTail),
    .physSrcA(physSrcA), .physSrcB(physSrcB), .physNew(physDst),
    .physOld(physOld), .headDone(headDone), .headOld(retPhys)
  );

  assign renTag = alTail;
endmodule

// File: tb/regRenamer_test.sv
`timescale 1ns/1ps
module regRenamer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic renValid = 1'b0;
  logic [4:0] renSrcA = '0, renSrcB = '0, renDst = '0;
  logic renReady;
  logic [5:0] physSrcA, physSrcB, physDst, physOld, retPhys;
  logic [4:0] renTag;
  logic cmpValid = 1'b0;
  logic [4:0] cmpTag = '0;
  logic retValid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int mMap [32];
  int mFree [32];
  int mOld [32];
  bit mDone [32];
  int mFh, mFt, mFreeCnt, mHead, mTail, mCnt;

  always #2.5 clk = ~clk;

  regRenamer uut (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renSrcA(renSrcA),
    .renSrcB(renSrcB), .renDst(renDst), .renReady(renReady),
    .physSrcA(physSrcA), .physSrcB(physSrcB), .physDst(physDst),
    .physOld(physOld), .renTag(renTag), .cmpValid(cmpValid),
    .cmpTag(cmpTag), .retValid(retValid), .retPhys(retPhys)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 32; i++) begin
      mMap[i] = i; mFree[i] = 32 + i; mOld[i] = 0; mDone[i] = 0;
    end
    mFh = 0; mFt = 0; mFreeCnt = 32; mHead = 0; mTail = 0; mCnt = 0;
  endtask

  // checks outputs against the model a little after the falling edge, then advances one cycle
  task automatic step();
    bit expRet, expReady;
    #1;
    expRet = (mCnt != 0) && mDone[mHead];
    chk("R7 retValid", int'(retValid), int'(expRet));
    if (expRet) chk("R7 retPhys", int'(retPhys), mOld[mHead]);
    expReady = (mFreeCnt != 0) && (mCnt < 32);
    chk("R8 renReady", int'(renReady), int'(expReady));
    chk("R5 renTag", int'(renTag), mTail);
    chk("R2 physSrcA", int'(physSrcA), mMap[renSrcA]);
    chk("R2 physSrcB", int'(physSrcB), mMap[renSrcB]);
    if (renValid && expReady) begin
      chk("R4 physDst", int'(physDst), mFree[mFh]);
      chk("R3 physOld", int'(physOld), mMap[renDst]);
    end
    if (cmpValid) mDone[cmpTag] = 1;
    if (expRet) begin
      mFree[mFt] = mOld[mHead];
      mFt = (mFt + 1) % 32; mFreeCnt++;
      mDone[mHead] = 0;
      mHead = (mHead + 1) % 32; mCnt--;
    end
    if (renValid && expReady) begin
      mOld[mTail] = mMap[renDst];
      mDone[mTail] = 0;
      mMap[renDst] = mFree[mFh];
      mFh = (mFh + 1) % 32; mFreeCnt--;
      mTail = (mTail + 1) % 32; mCnt++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(bit rv, int a, int b, int d, bit cv, int ct);
    renValid = rv; renSrcA = 5'(a); renSrcB = 5'(b); renDst = 5'(d);
    cmpValid = cv; cmpTag = 5'(ct);
  endtask

  task automatic testReset();
    rstN = 0;
    drive(0, 5, 31, 0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    #1;
    chk("R1 map r5", int'(physSrcA), 5);
    chk("R1 map r31", int'(physSrcB), 31);
    chk("R1 tag", int'(renTag), 0);
    chk("R1 retValid", int'(retValid), 0);
    chk("R1 renReady", int'(renReady), 1);
    step();
  endtask

  task automatic testFirstRenames();
    drive(1, 3, 4, 7, 0, 0);
    #1;
    chk("R4 first dst", int'(physDst), 32);
    chk("R3 first old", int'(physOld), 7);
    step();
    drive(1, 7, 2, 7, 0, 0);
    #1;
    chk("R2 renamed src", int'(physSrcA), 32);
    chk("R3 chained old", int'(physOld), 32);
    chk("R5 second tag", int'(renTag), 1);
    step();
    drive(1, 9, 9, 9, 0, 0);
    #1;
    chk("R2 self src", int'(physSrcA), 9);
    chk("R4 third dst", int'(physDst), 34);
    step();
    drive(0, 9, 7, 0, 0, 0);
    #1;
    chk("R3 map r9", int'(physSrcA), 34);
    chk("R3 map r7", int'(physSrcB), 33);
    step();
  endtask

  task automatic testOutOfOrder();
    drive(0, 0, 0, 0, 1, 2);
    step();
    drive(0, 0, 0, 0, 0, 0);
    #1;
    chk("R6 young done no retire", int'(retValid), 0);
    step();
    drive(0, 0, 0, 0, 1, 0);
    step();
    drive(0, 0, 0, 0, 1, 1);
    #1;
    chk("R7 head retires", int'(retValid), 1);
    chk("R7 head phys", int'(retPhys), 7);
    step();
    drive(0, 0, 0, 0, 0, 0);
    #1;
    chk("R7 second phys", int'(retPhys), 32);
    repeat (4) step();
    chk("R7 list drained", int'(retValid), 0);
  endtask

  task automatic testFill();
    for (int k = 0; k < 32; k++) begin
      drive(1, k, (k + 1) % 32, (k * 5) % 32, 0, 0);
      #1;
      if (k == 29) chk("R4 fifo reuse", int'(physDst), 7);
      step();
    end
    drive(1, 0, 1, 0, 0, 0);
    #1;
    chk("R8 full stall", int'(renReady), 0);
    step();
    step();
    drive(0, 0, 0, 0, 0, 0);
    #1;
    chk("R8 tag held", int'(renTag), 3);
    step();
  endtask

  task automatic testSimultaneous();
    drive(0, 0, 0, 0, 1, 3);
    step();
    drive(0, 0, 0, 0, 1, 4);
    step();
    drive(1, 1, 2, 6, 0, 0);
    #1;
    chk("R9 retire with rename", int'(retValid), 1);
    chk("R9 ready after release", int'(renReady), 1);
    step();
    #1;
    chk("R9 one slot left", int'(renReady), 1);
    step();
    #1;
    chk("R9 full again", int'(renReady), 0);
    step();
    drive(0, 0, 0, 0, 0, 0);
    for (int j = 31; j >= 0; j--) begin
      drive(0, 0, 0, 0, 1, (mHead + j) % 32);
      step();
    end
    drive(0, 0, 0, 0, 0, 0);
    repeat (34) step();
    chk("R7 all retired", int'(retValid), 0);
    chk("R8 ready when empty", int'(renReady), 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk);
    testReset();
    testFirstRenames();
    testOutOfOrder();
    testFill();
    testSimultaneous();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule